// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a watchdog that software programs over a small register interface clocked by a peripheral clock, while the timing itself runs from a separate oscillator clock. Software loads a 12-bit period, optionally clears the running count, and then starts the counter, which cannot be stopped again except by a module reset. A prescaler divides the oscillator clock by a power of two, and an overflow cycle is complete when the divided count passes the programmed period.

Refreshing is done by writing a one to the low bit of the interrupt register, which clears both the pending interrupt and the elapsed time. If software stops refreshing, the first overflow raises the interrupt output and the next consecutive overflow drives the active-low reset output, which then stays low until the block itself is reset. A test path can force a parity error, which pulls the reset output low when the parity-error control register holds zero.

Register writes that configure the counter are carried into the oscillator domain by a toggle request/acknowledge handshake. A busy flag stays readable while a transfer is in flight, and a configuration write issued during that time is dropped.

Top module: `wdt_top`

## Requirements
- R1: The period register (offset 0x04) keeps a 12-bit field in bits 31:20; bits 19:0 of a write are discarded and read back as zero.
- R2: One overflow cycle lasts 2^PRESCALE_LOG2 × (period + 1) oscillator cycles, counted from the moment the count was last restarted; the prescaler does not advance while the counter is disabled.
- R3: The first overflow without a refresh sets `irq_o`; the next consecutive overflow drives `wdt_rst_n_o` low exactly one overflow cycle after `irq_o` rose.
- R4: Writing bit 0 = 1 to the interrupt register (offset 0x0C) clears `irq_o`, the overflow history and the elapsed count; writing bit 0 = 0 there changes nothing.
- R5: Bit 0 of the control register (offset 0x00) starts the counter and reads back as 1; a later write of 0 is ignored, and only `rst_n` clears it.
- R6: Any write to the counter register (offset 0x08) restarts the current overflow cycle from zero.
- R7: Writing bit 0 = 1 to the parity-force register (offset 0x14) drives `wdt_rst_n_o` low when bit 0 of the parity-control register (offset 0x10) is 0, and has no effect on the reset output when it is 1.
- R8: Writes to offsets 0x00, 0x04, 0x08, 0x10 and 0x14 take effect in the oscillator domain 2 to 4 oscillator cycles after the write; bit 1 of the control register reads 1 while any write is in transit, and a write to one of those offsets during that time is dropped.
- R9: Once low, `wdt_rst_n_o` stays low until `rst_n` is asserted; a refresh does not release it.
- R10: Bit 0 of the interrupt register reads back the current state of the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral (register) clock |
| osc_clk | input | 1 | Oscillator clock for the counter |
| rst_n | input | 1 | Asynchronous active-low module reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid the cycle after |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Overflow interrupt, oscillator domain |
| wdt_rst_n_o | output | 1 | Active-low reset request, oscillator domain |

## Verification
A register write reaches the counter 2 to 4 oscillator cycles after the bus edge, so an interrupt is due between 24 and 30 oscillator cycles after the refreshing or restarting write, for a bench prescale of 8 and a period of 2, and a forced parity error lowers the reset output within 1 to 6 cycles. Because both overflows are counted in the same domain, the reset edge must land exactly one overflow cycle after the interrupt edge, and this is checked with no tolerance. The driver pushes each expected edge with its window into a queue when it issues the causing write, and a monitor sampling on the falling oscillator edge pops and compares every interrupt rise and reset fall as it appears; level checks, such as the interrupt staying set after a zero write, are taken a fixed number of cycles after the write settles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PERIOD  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_COUNT   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_IRQ     = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_PECTL   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_PEFORCE = 5'h14;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    CFG_CTRL    = 3'd0,
    CFG_PERIOD  = 3'd1,
    CFG_COUNT   = 3'd2,
    CFG_PECTL   = 3'd3,
    CFG_PEFORCE = 3'd4
  } cfg_sel_e;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;

endmodule

// File: rtl/wdt_cdc_xfer.sv
module wdt_cdc_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_req,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);

  // source side
  logic         tgl_q, tgl_d;
  logic [W-1:0] hold_q, hold_d;
  logic         ack_s1_q, ack_s2_q;
  // destination side
  logic         req_s1_q, req_s2_q, req_s3_q;

  assign src_busy = tgl_q ^ ack_s2_q;

  always_comb begin
    tgl_d  = tgl_q;
    hold_d = hold_q;
    if (src_req && !src_busy) begin
      tgl_d  = ~tgl_q;
      hold_d = src_data;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      tgl_q    <= 1'b0;
      hold_q   <= '0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      tgl_q    <= tgl_d;
      hold_q   <= hold_d;
      ack_s1_q <= req_s3_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      req_s3_q <= 1'b0;
    end else begin
      req_s1_q <= tgl_q;
      req_s2_q <= req_s1_q;
      req_s3_q <= req_s2_q;
    end
  end

  assign dst_valid = req_s2_q ^ req_s3_q;
  assign dst_data  = hold_q;

  AST_SRC_HOLD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy |=> $stable(hold_q)); // R8

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_busy,
  input  logic              ref_busy,
  input  logic              irq_async,
  output logic              cfg_req,
  output cfg_sel_e          cfg_sel,
  output logic [PERIOD_W-1:0] cfg_data,
  output logic              ref_req,
  output logic              ref_data
);

  localparam int unsigned PLSB = DATA_W - PERIOD_W;

  logic                en_sh_q, en_sh_d;
  logic [PERIOD_W-1:0] per_sh_q, per_sh_d;
  logic [DATA_W-1:0]   cnt_sh_q, cnt_sh_d;
  logic                pectl_sh_q, pectl_sh_d;
  logic                pefrc_sh_q, pefrc_sh_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                irq_s1_q, irq_s2_q;
  logic                hit_cfg;
  logic                accept;

  // decode of the oscillator-side registers
  always_comb begin
    hit_cfg = 1'b1;
    cfg_sel = CFG_CTRL;
    unique case (bus_addr)
      OFS_CTRL:    cfg_sel = CFG_CTRL;
      OFS_PERIOD:  cfg_sel = CFG_PERIOD;
      OFS_COUNT:   cfg_sel = CFG_COUNT;
      OFS_PECTL:   cfg_sel = CFG_PECTL;
      OFS_PEFORCE: cfg_sel = CFG_PEFORCE;
      default:     hit_cfg = 1'b0;
    endcase
  end

  assign accept   = bus_wr && hit_cfg && !cfg_busy;
  assign cfg_req  = accept;
  assign cfg_data = (cfg_sel == CFG_PERIOD) ? bus_wdata[DATA_W-1:PLSB]
                                            : {{(PERIOD_W-1){1'b0}}, bus_wdata[0]};
  assign ref_req  = bus_wr && (bus_addr == OFS_IRQ) && !ref_busy;
  assign ref_data = bus_wdata[0];

  always_comb begin
    en_sh_d    = en_sh_q;
    per_sh_d   = per_sh_q;
    cnt_sh_d   = cnt_sh_q;
    pectl_sh_d = pectl_sh_q;
    pefrc_sh_d = pefrc_sh_q;
    if (accept) begin
      unique case (cfg_sel)
        CFG_CTRL:    en_sh_d    = en_sh_q | bus_wdata[0];
        CFG_PERIOD:  per_sh_d   = bus_wdata[DATA_W-1:PLSB];
        CFG_COUNT:   cnt_sh_d   = bus_wdata;
        CFG_PECTL:   pectl_sh_d = bus_wdata[0];
        CFG_PEFORCE: pefrc_sh_d = bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      unique case (bus_addr)
        OFS_CTRL:    rdata_d[1:0] = {cfg_busy | ref_busy, en_sh_q};
        OFS_PERIOD:  rdata_d[DATA_W-1:PLSB] = per_sh_q;
        OFS_COUNT:   rdata_d = cnt_sh_q;
        OFS_IRQ:     rdata_d[0] = irq_s2_q;
        OFS_PECTL:   rdata_d[0] = pectl_sh_q;
        OFS_PEFORCE: rdata_d[0] = pefrc_sh_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh_q    <= 1'b0;
      per_sh_q   <= '0;
      cnt_sh_q   <= '0;
      pectl_sh_q <= 1'b0;
      pefrc_sh_q <= 1'b0;
      rdata_q    <= '0;
      irq_s1_q   <= 1'b0;
      irq_s2_q   <= 1'b0;
    end else begin
      en_sh_q    <= en_sh_d;
      per_sh_q   <= per_sh_d;
      cnt_sh_q   <= cnt_sh_d;
      pectl_sh_q <= pectl_sh_d;
      pefrc_sh_q <= pefrc_sh_d;
      rdata_q    <= rdata_d;
      irq_s1_q   <= irq_async;
      irq_s2_q   <= irq_s1_q;
    end
  end

  assign bus_rdata = rdata_q;

  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg && cfg_busy) |=>
      ($stable(per_sh_q) && $stable(cnt_sh_q) && $stable(pectl_sh_q) && $stable(pefrc_sh_q))); // R8

  AST_EN_SHADOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_sh_q |=> en_sh_q); // R5

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned PERIOD_W = 12,
  parameter int unsigned PRE_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  input  cfg_sel_e            cfg_sel,
  input  logic [PERIOD_W-1:0] cfg_data,
  input  logic                ref_valid,
  input  logic                ref_data,
  output logic                irq_o,
  output logic                wdt_rst_n_o
);

  logic                en_q, en_d;
  logic [PERIOD_W-1:0] set_q, set_d;
  logic                pectl_q, pectl_d;
  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [PERIOD_W-1:0] pcnt_q, pcnt_d;
  logic                seen_q, seen_d;
  logic                irq_q, irq_d;
  logic                trip_q, trip_d;
  logic                tick, wrap, refresh, pe_fire;

  assign tick    = en_q && (pre_q == {PRE_W{1'b1}});
  assign wrap    = tick && (pcnt_q >= set_q);
  assign refresh = ref_valid && ref_data;
  assign pe_fire = cfg_valid && (cfg_sel == CFG_PEFORCE) && cfg_data[0] && !pectl_q;

  always_comb begin
    en_d    = en_q;
    set_d   = set_q;
    pectl_d = pectl_q;
    pre_d   = pre_q;
    pcnt_d  = pcnt_q;
    seen_d  = seen_q;
    irq_d   = irq_q;
    trip_d  = trip_q;

    if (en_q) pre_d = pre_q + 1'b1;
    if (tick) pcnt_d = wrap ? '0 : pcnt_q + 1'b1;

    if (wrap && !refresh) begin
      if (!seen_q) begin
        seen_d = 1'b1;
        irq_d  = 1'b1;
      end else begin
        trip_d = 1'b1;
      end
    end

    if (pe_fire) trip_d = 1'b1;

    if (cfg_valid) begin
      unique case (cfg_sel)
        CFG_CTRL:   en_d    = en_q | cfg_data[0];
        CFG_PERIOD: set_d   = cfg_data;
        CFG_COUNT: begin
          pre_d  = '0;
          pcnt_d = '0;
        end
        CFG_PECTL:  pectl_d = cfg_data[0];
        default: ;
      endcase
    end

    if (refresh) begin
      pre_d  = '0;
      pcnt_d = '0;
      seen_d = 1'b0;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      set_q   <= '0;
      pectl_q <= 1'b0;
      pre_q   <= '0;
      pcnt_q  <= '0;
      seen_q  <= 1'b0;
      irq_q   <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      set_q   <= set_d;
      pectl_q <= pectl_d;
      pre_q   <= pre_d;
      pcnt_q  <= pcnt_d;
      seen_q  <= seen_d;
      irq_q   <= irq_d;
      trip_q  <= trip_d;
    end
  end

  assign irq_o       = irq_q;
  assign wdt_rst_n_o = !trip_q;

  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trip_q) && !$past(pe_fire)) |-> $past(irq_q)); // R3

  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_rst_n_o |=> !wdt_rst_n_o); // R9

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R5

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !irq_o); // R4

  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pre_q == '0)); // R2

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned PERIOD_W      = 12,
  parameter int unsigned PRESCALE_LOG2 = 20
) (
  input  logic              pclk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_n_o
);

  localparam int unsigned CFG_W = SEL_W + PERIOD_W;

  logic                p_rst_n, o_rst_n;
  logic                cfg_req, cfg_busy, ref_req, ref_busy;
  cfg_sel_e            cfg_sel_p;
  logic [PERIOD_W-1:0] cfg_data_p;
  logic                ref_data_p;
  logic                cfg_valid_o, ref_valid_o;
  logic [CFG_W-1:0]    cfg_bus_o;
  logic [0:0]          ref_bus_o;

  wdt_rst_sync u_rst_p (.clk(pclk),    .arst_n(rst_n), .srst_n(p_rst_n));
  wdt_rst_sync u_rst_o (.clk(osc_clk), .arst_n(rst_n), .srst_n(o_rst_n));

  wdt_regs #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk(pclk), .rst_n(p_rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_busy(cfg_busy), .ref_busy(ref_busy), .irq_async(irq_o),
    .cfg_req(cfg_req), .cfg_sel(cfg_sel_p), .cfg_data(cfg_data_p),
    .ref_req(ref_req), .ref_data(ref_data_p)
  );

  wdt_cdc_xfer #(.W(CFG_W)) u_cfg_xfer (
    .src_clk(pclk), .src_rst_n(p_rst_n), .src_req(cfg_req),
    .src_data({cfg_sel_p, cfg_data_p}), .src_busy(cfg_busy),
    .dst_clk(osc_clk), .dst_rst_n(o_rst_n),
    .dst_valid(cfg_valid_o), .dst_data(cfg_bus_o)
  );

  wdt_cdc_xfer #(.W(1)) u_ref_xfer (
    .src_clk(pclk), .src_rst_n(p_rst_n), .src_req(ref_req),
    .src_data(ref_data_p), .src_busy(ref_busy),
    .dst_clk(osc_clk), .dst_rst_n(o_rst_n),
    .dst_valid(ref_valid_o), .dst_data(ref_bus_o)
  );

  wdt_core #(.PERIOD_W(PERIOD_W), .PRE_W(PRESCALE_LOG2)) u_core (
    .clk(osc_clk), .rst_n(o_rst_n),
    .cfg_valid(cfg_valid_o),
    .cfg_sel(cfg_sel_e'(cfg_bus_o[CFG_W-1:PERIOD_W])),
    .cfg_data(cfg_bus_o[PERIOD_W-1:0]),
    .ref_valid(ref_valid_o), .ref_data(ref_bus_o[0]),
    .irq_o(irq_o), .wdt_rst_n_o(wdt_rst_n_o)
  );

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  import wdt_pkg::*;

  localparam int PRE = 3;

  logic        pclk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdt_rst_n_o;

  int checks = 0;
  int failures = 0;
  int ocyc = 0;
  int last_evt = 0;
  bit done = 1'b0;

  int    q_kind[$];
  bit    q_rel[$];
  int    q_lo[$];
  int    q_hi[$];
  string q_req[$];

  always #4  pclk = ~pclk;      // 125 MHz register clock
  always #10 osc_clk = ~osc_clk;

  wdt_top #(.PRESCALE_LOG2(PRE)) dut (
    .pclk(pclk), .osc_clk(osc_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_n_o(wdt_rst_n_o)
  );

  always @(posedge osc_clk) ocyc <= ocyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_edge(input int kind, input bit rel, input int lo,
                             input int hi, input string req);
    q_kind.push_back(kind);
    q_rel.push_back(rel);
    q_lo.push_back(lo);
    q_hi.push_back(hi);
    q_req.push_back(req);
  endtask

  // monitor side: kind 0 = irq rise, kind 1 = reset fall
  task automatic observe(input int kind);
    int t;
    t = ocyc;
    if (q_kind.size() == 0) begin
      check(1'b0, "R3", "unexpected edge kind", kind, -1);
    end else begin
      int k, lo, hi;
      bit r;
      string req;
      k = q_kind.pop_front();
      r = q_rel.pop_front();
      lo = q_lo.pop_front();
      hi = q_hi.pop_front();
      req = q_req.pop_front();
      if (r) begin
        lo += last_evt;
        hi += last_evt;
      end
      check(k == kind, req, "edge kind", kind, k);
      check(t >= lo && t <= hi, req, "edge cycle (expected is low bound)", t, lo);
    end
    last_evt = t;
  endtask

  logic irq_prev = 1'b0;
  logic rst_prev = 1'b1;
  always @(negedge osc_clk) begin
    if (irq_o === 1'b1 && irq_prev === 1'b0) observe(0);
    if (wdt_rst_n_o === 1'b0 && rst_prev === 1'b1) observe(1);
    irq_prev = irq_o;
    rst_prev = wdt_rst_n_o;
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d, output int w);
    @(negedge pclk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    w = ocyc;
    @(negedge pclk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk);
    bus_rd = 1'b1;
    bus_addr = a;
    @(negedge pclk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      bus_read(OFS_CTRL, v);
      if (!v[1]) break;
    end
  endtask

  task automatic osc_wait(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic wait_level(input bit want_irq, input logic lvl);
    for (int i = 0; i < 400; i++) begin
      @(negedge osc_clk);
      if (want_irq ? (irq_o == lvl) : (wdt_rst_n_o == lvl)) break;
    end
  endtask

  task automatic module_reset();
    rst_n = 1'b0;
    osc_wait(3);
    rst_n = 1'b1;
    osc_wait(3);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int w;

    osc_wait(4);
    rst_n = 1'b1;
    osc_wait(3);

    // reset state
    check(irq_o == 1'b0, "R3", "irq after reset", irq_o, 0);
    check(wdt_rst_n_o == 1'b1, "R9", "reset output after reset", wdt_rst_n_o, 1);
    bus_read(OFS_PERIOD, v);
    check(v == 32'h0, "R1", "period after reset", v, 0);

    // period field masking, busy flag and dropped write
    bus_write(OFS_PERIOD, 32'h002F_FFFF, w);
    bus_write(OFS_PERIOD, 32'h0050_0000, w);
    bus_read(OFS_CTRL, v);
    check(v[1] == 1'b1, "R8", "busy during transfer", v[1], 1);
    wait_idle();
    bus_read(OFS_PERIOD, v);
    check(v == 32'h0020_0000, "R1", "period readback masked, late write dropped (R8)", v, 32'h0020_0000);

    // start, then try to stop
    bus_write(OFS_COUNT, 32'h0, w);
    wait_idle();
    bus_write(OFS_CTRL, 32'h1, w);
    wait_idle();
    bus_write(OFS_CTRL, 32'h0, w);
    wait_idle();
    bus_read(OFS_CTRL, v);
    check(v[0] == 1'b1, "R5", "enable ignores write of 0", v[0], 1);

    // regular refreshes keep the interrupt away (monitor flags any edge)
    for (int i = 0; i < 6; i++) begin
      bus_write(OFS_IRQ, 32'h1, w);
      osc_wait(14);
    end
    check(irq_o == 1'b0, "R4", "no irq while refreshed", irq_o, 0);

    // stop refreshing: irq after one period, reset after another (R2, R3)
    bus_write(OFS_IRQ, 32'h1, w);
    expect_edge(0, 1'b0, w + 24, w + 30, "R2");
    expect_edge(1, 1'b1, 24, 24, "R3");
    wait_level(1'b1, 1'b1);
    bus_read(OFS_IRQ, v);
    check(v[0] == 1'b1, "R10", "irq readback", v[0], 1);
    bus_write(OFS_IRQ, 32'h0, w);
    osc_wait(8);
    check(irq_o == 1'b1, "R4", "zero write leaves irq", irq_o, 1);
    wait_level(1'b0, 1'b0);

    // refresh after reset output went low
    bus_write(OFS_IRQ, 32'h1, w);
    expect_edge(0, 1'b0, w + 24, w + 30, "R4");
    osc_wait(10);
    check(wdt_rst_n_o == 1'b0, "R9", "reset output held after refresh", wdt_rst_n_o, 0);
    check(irq_o == 1'b0, "R4", "refresh clears irq", irq_o, 0);
    bus_read(OFS_IRQ, v);
    check(v[0] == 1'b0, "R10", "irq readback cleared", v[0], 0);
    wait_level(1'b1, 1'b1);

    module_reset();
    check(wdt_rst_n_o == 1'b1, "R9", "module reset releases output", wdt_rst_n_o, 1);
    check(irq_o == 1'b0, "R3", "irq cleared by module reset", irq_o, 0);
    bus_read(OFS_CTRL, v);
    check(v[0] == 1'b0, "R5", "enable cleared by module reset", v[0], 0);

    // period 4, restart through the counter register
    bus_write(OFS_PERIOD, 32'h0040_0000, w);
    wait_idle();
    bus_write(OFS_CTRL, 32'h1, w);
    wait_idle();
    osc_wait(20);
    bus_write(OFS_COUNT, 32'h0, w);
    expect_edge(0, 1'b0, w + 40, w + 46, "R6");
    expect_edge(1, 1'b1, 40, 40, "R2");
    wait_level(1'b0, 1'b0);
    check(wdt_rst_n_o == 1'b0, "R3", "second overflow asserted reset", wdt_rst_n_o, 0);

    module_reset();

    // parity path
    bus_write(OFS_PECTL, 32'h1, w);
    wait_idle();
    bus_write(OFS_PEFORCE, 32'h1, w);
    wait_idle();
    osc_wait(20);
    check(wdt_rst_n_o == 1'b1, "R7", "masked parity error", wdt_rst_n_o, 1);
    bus_write(OFS_PECTL, 32'h0, w);
    wait_idle();
    bus_read(OFS_PECTL, v);
    check(v[0] == 1'b0, "R7", "parity control readback", v[0], 0);
    bus_write(OFS_PEFORCE, 32'h1, w);
    expect_edge(1, 1'b0, w + 1, w + 6, "R7");
    osc_wait(12);
    check(wdt_rst_n_o == 1'b0, "R7", "forced parity error resets", wdt_rst_n_o, 0);

    osc_wait(30);
    check(q_kind.size() == 0, "R3", "expected edges still pending", q_kind.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule